// File: doc/BRIEF.md
# Programmable Logic Tree Evaluator

This block evaluates a learned logic network: a complete binary tree of fixed depth whose internal nodes each combine two binary children, and whose leaves each pick one bit of the input vector, either true or inverted. The tree computes one output bit in a single feedforward pass. It holds no state inside the tree, and every signal in the tree is one bit wide.

Software or a training engine loads the tree shape before use, one word per write. It writes a leaf's selector word or a node's function code through a word-wide configuration port. After that, each cycle with `in_valid` high evaluates the presented input vector. The result is registered and appears one cycle later together with a one-cycle `out_valid` pulse.

Nodes are numbered in heap order. Node 0 is the root, and node k has its left child at position 2k+1 and its right child at 2k+2. Positions from NODES onward are leaves, so leaf i sits at heap position NODES+i, and leaf 0 is the leftmost.

Top module: `logic_tree_eval`

## Requirements
- R1: After reset, `out_valid` and `out_bit` are 0. Every node is AND, and every leaf selects input 0 uncomplemented, so an evaluation returns `in_bits[0]`.
- R2: A leaf whose word is {inv, idx} (inv at bit IDX_W, idx in bits IDX_W-1:0) yields `in_bits[idx]` when inv is 0, and its complement when inv is 1.
- R3: A node with code 2'b00 outputs the AND of its two children.
- R4: A node with code 2'b01 outputs the OR of its two children.
- R5: A node with code 2'b10 forwards its left child (heap 2k+1). A node with code 2'b11 forwards its right child (heap 2k+2).
- R6: Leaf address i is heap position NODES+i. Leaves 0..LEAVES/2-1 therefore lie under the root's left child.
- R7: A configuration write presented in a cycle with `in_valid` high is dropped.
- R8: The result of an evaluation appears one cycle after `in_valid`, with `out_valid` high for that one cycle only. `out_bit` holds its value in cycles without an evaluation. Back-to-back evaluations produce back-to-back results.
- R9: A node write (`cfg_is_node`=1) to an address of NODES or above changes no configuration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_is_node | input | 1 | 1: write node function, 0: write leaf selector |
| cfg_addr | input | DEPTH | Leaf or node index |
| cfg_data | input | IDX_W+1 | Leaf word {inv, idx}; node code in bits 1:0 |
| in_valid | input | 1 | Evaluate `in_bits` this cycle |
| in_bits | input | N_INPUTS | Binary input vector |
| out_valid | output | 1 | One-cycle pulse marking a new result |
| out_bit | output | 1 | Registered tree output |

## Verification
A corrupted node code or leaf selector cannot be seen directly. It shows up only as a wrong `out_bit` on the first evaluation whose input pattern makes that node or leaf decisive, one cycle after `in_valid`. The stimulus therefore includes patterns that separate AND from OR and LEFT from RIGHT, and that distinguish true from inverted leaves. A dropped or misplaced write is likewise detected on the next evaluation that depends on the affected position.

// File: rtl/ltree_pkg.sv
package ltree_pkg;
  typedef enum logic [1:0] {
    FN_AND   = 2'b00,
    FN_OR    = 2'b01,
    FN_LEFT  = 2'b10,
    FN_RIGHT = 2'b11
  } node_fn_e;

  function automatic logic node_op(input logic [1:0] code, input logic lhs, input logic rhs);
    case (node_fn_e'(code))
      FN_AND:   node_op = lhs & rhs;
      FN_OR:    node_op = lhs | rhs;
      FN_LEFT:  node_op = lhs;
      default:  node_op = rhs;
    endcase
  endfunction
endpackage

// File: rtl/ltree_cfg_store.sv
module ltree_cfg_store #(
  parameter int N_INPUTS = 8,
  parameter int DEPTH    = 3,
  localparam int LEAVES  = 1 << DEPTH,
  localparam int NODES   = LEAVES - 1,
  localparam int IDX_W   = $clog2(N_INPUTS),
  localparam int LEAF_W  = IDX_W + 1
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           cfg_we,
  input  logic                           cfg_is_node,
  input  logic [DEPTH-1:0]               cfg_addr,
  input  logic [LEAF_W-1:0]              cfg_data,
  input  logic                           in_valid,
  output logic [LEAVES-1:0][LEAF_W-1:0]  leaf_cfg,
  output logic [NODES-1:0][1:0]          node_cfg
);
  localparam logic [DEPTH-1:0] LAST_NODE = DEPTH'(NODES - 1);

  logic wr_ok;
  assign wr_ok = cfg_we && !in_valid;

  always_ff @(posedge clk) begin
    if (rst) begin
      leaf_cfg <= '0;
      node_cfg <= '0;
    end else if (wr_ok) begin
      if (cfg_is_node) begin
        if (cfg_addr <= LAST_NODE) node_cfg[cfg_addr] <= cfg_data[1:0];
      end else begin
        leaf_cfg[cfg_addr] <= cfg_data;
      end
    end
  end

  assert_reset_default_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (leaf_cfg == '0 && node_cfg == '0));

  assert_no_write_during_eval_R7: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> ($stable(leaf_cfg) && $stable(node_cfg)));

  assert_node_range_R9: assert property (@(posedge clk) disable iff (rst)
    (cfg_we && cfg_is_node && cfg_addr > LAST_NODE) |=> ($stable(node_cfg) && $stable(leaf_cfg)));
endmodule

// File: rtl/ltree_leaf_mux.sv
module ltree_leaf_mux #(
  parameter int N_INPUTS = 8,
  parameter int DEPTH    = 3,
  localparam int LEAVES  = 1 << DEPTH,
  localparam int IDX_W   = $clog2(N_INPUTS),
  localparam int LEAF_W  = IDX_W + 1
) (
  input  logic [N_INPUTS-1:0]            in_bits,
  input  logic [LEAVES-1:0][LEAF_W-1:0]  leaf_cfg,
  output logic [LEAVES-1:0]              leaf_bits
);
  for (genvar i = 0; i < LEAVES; i++) begin : g_leaf
    assign leaf_bits[i] = in_bits[leaf_cfg[i][IDX_W-1:0]] ^ leaf_cfg[i][IDX_W];
  end
endmodule

// File: rtl/ltree_node_net.sv
module ltree_node_net #(
  parameter int DEPTH   = 3,
  localparam int LEAVES = 1 << DEPTH,
  localparam int NODES  = LEAVES - 1,
  localparam int TOTAL  = NODES + LEAVES
) (
  input  logic [LEAVES-1:0]     leaf_bits,
  input  logic [NODES-1:0][1:0] node_cfg,
  output logic                  root_bit
);
  import ltree_pkg::*;

  logic [TOTAL-1:0] heap;

  assign heap[TOTAL-1:NODES] = leaf_bits;

  for (genvar k = 0; k < NODES; k++) begin : g_node
    assign heap[k] = node_op(node_cfg[k], heap[2*k+1], heap[2*k+2]);
  end

  assign root_bit = heap[0];
endmodule

// File: rtl/logic_tree_eval.sv
module logic_tree_eval #(
  parameter int N_INPUTS = 8,
  parameter int DEPTH    = 3,
  localparam int LEAVES  = 1 << DEPTH,
  localparam int NODES   = LEAVES - 1,
  localparam int IDX_W   = $clog2(N_INPUTS),
  localparam int LEAF_W  = IDX_W + 1
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                cfg_we,
  input  logic                cfg_is_node,
  input  logic [DEPTH-1:0]    cfg_addr,
  input  logic [LEAF_W-1:0]   cfg_data,
  input  logic                in_valid,
  input  logic [N_INPUTS-1:0] in_bits,
  output logic                out_valid,
  output logic                out_bit
);
  logic [LEAVES-1:0][LEAF_W-1:0] leaf_cfg;
  logic [NODES-1:0][1:0]         node_cfg;
  logic [LEAVES-1:0]             leaf_bits;
  logic                          root_bit;

  ltree_cfg_store #(.N_INPUTS(N_INPUTS), .DEPTH(DEPTH)) u_cfg (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_is_node(cfg_is_node),
    .cfg_addr(cfg_addr), .cfg_data(cfg_data), .in_valid(in_valid),
    .leaf_cfg(leaf_cfg), .node_cfg(node_cfg)
  );

  ltree_leaf_mux #(.N_INPUTS(N_INPUTS), .DEPTH(DEPTH)) u_leaf (
    .in_bits(in_bits), .leaf_cfg(leaf_cfg), .leaf_bits(leaf_bits)
  );

  ltree_node_net #(.DEPTH(DEPTH)) u_net (
    .leaf_bits(leaf_bits), .node_cfg(node_cfg), .root_bit(root_bit)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_bit   <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) out_bit <= root_bit;
    end
  end

  assert_result_follows_R8: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);

  assert_idle_holds_R8: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> (!out_valid && $stable(out_bit)));
endmodule

// File: tb/logic_tree_eval_tb.sv
`timescale 1ns/1ps
module logic_tree_eval_tb;
  localparam int N  = 8;
  localparam int D  = 3;
  localparam int LW = $clog2(N) + 1;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          cfg_we = 1'b0;
  logic          cfg_is_node = 1'b0;
  logic [D-1:0]  cfg_addr = '0;
  logic [LW-1:0] cfg_data = '0;
  logic          in_valid = 1'b0;
  logic [N-1:0]  in_bits = '0;
  logic          out_valid;
  logic          out_bit;

  int checks = 0;
  int fails  = 0;

  always #2.5 clk = ~clk;

  logic_tree_eval #(.N_INPUTS(N), .DEPTH(D)) u_dut (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_is_node(cfg_is_node),
    .cfg_addr(cfg_addr), .cfg_data(cfg_data), .in_valid(in_valid),
    .in_bits(in_bits), .out_valid(out_valid), .out_bit(out_bit)
  );

  // {input vector, expected}: root OR, other nodes AND, leaf i -> input i (R3, R4, R6)
  localparam logic [8:0] VEC [8] = '{
    {8'h0F, 1'b1}, {8'hF0, 1'b1}, {8'h0E, 1'b0}, {8'h7F, 1'b1},
    {8'h77, 1'b0}, {8'hFF, 1'b1}, {8'h00, 1'b0}, {8'hE0, 1'b0}
  };

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic wr(input logic node, input int addr, input logic [LW-1:0] data);
    @(negedge clk);
    cfg_we = 1'b1; cfg_is_node = node; cfg_addr = D'(addr); cfg_data = data;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic eval(input logic [N-1:0] v, input logic exp, input string req);
    @(negedge clk);
    in_bits = v; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check(req, out_valid, 1'b1);
    check(req, out_bit, exp);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state and default configuration
    check("R1", out_valid, 1'b0);
    check("R1", out_bit, 1'b0);
    eval(8'h01, 1'b1, "R1");
    eval(8'hFE, 1'b0, "R1");

    // configure identity leaves, root OR
    for (int i = 0; i < 8; i++) wr(1'b0, i, LW'(i));
    wr(1'b1, 0, 4'b0001);
    for (int t = 0; t < 8; t++) eval(VEC[t][8:1], VEC[t][0], "R6");

    // R2 complement on leaf 0 selecting input 5
    wr(1'b0, 0, 4'b1101);
    eval(8'h0E, 1'b1, "R2");
    eval(8'h2E, 1'b0, "R2");
    wr(1'b0, 0, 4'b0000);

    // R5 LEFT / RIGHT at root
    wr(1'b1, 0, 4'b0010);
    eval(8'hF0, 1'b0, "R5");
    eval(8'h0F, 1'b1, "R5");
    wr(1'b1, 0, 4'b0011);
    eval(8'hF0, 1'b1, "R5");
    eval(8'h0F, 1'b0, "R5");

    // R4 OR at node 3, root LEFT: (in0|in1)&in2&in3
    wr(1'b1, 0, 4'b0010);
    wr(1'b1, 3, 4'b0001);
    eval(8'h0D, 1'b1, "R4");
    eval(8'h0E, 1'b1, "R4");
    eval(8'h0C, 1'b0, "R4");
    eval(8'h07, 1'b0, "R3");

    // R7 write during evaluation dropped
    @(negedge clk);
    in_bits = 8'h0F; in_valid = 1'b1;
    cfg_we = 1'b1; cfg_is_node = 1'b1; cfg_addr = 3'd0; cfg_data = 4'b0011;
    @(negedge clk);
    in_valid = 1'b0; cfg_we = 1'b0;
    check("R7", out_bit, 1'b1);
    eval(8'h0F, 1'b1, "R7");

    // R9 node write beyond last node ignored
    wr(1'b1, 7, 4'b0011);
    eval(8'h0F, 1'b1, "R9");
    eval(8'hF0, 1'b0, "R9");

    // R8 pulse width, hold, back-to-back
    eval(8'h0F, 1'b1, "R8");
    in_bits = 8'h00;
    @(negedge clk);
    check("R8", out_valid, 1'b0);
    check("R8", out_bit, 1'b1);
    @(negedge clk);
    in_bits = 8'h0F; in_valid = 1'b1;
    @(negedge clk);
    in_bits = 8'h00;
    check("R8", out_valid, 1'b1);
    check("R8", out_bit, 1'b1);
    @(negedge clk);
    in_valid = 1'b0;
    check("R8", out_valid, 1'b1);
    check("R8", out_bit, 1'b0);
    @(negedge clk);
    check("R8", out_valid, 1'b0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule